// File: doc/BRIEF.md
# Zero-Substitution Line Decoder (B8ZS / HDB3)

This block sits behind the clock and data recovery stage of a multi-channel line receiver. Each channel delivers retimed bipolar symbols as a positive rail and a negative rail, qualified by a per-channel bit strobe. The block turns them into single-rail data. When decoding is active it removes the zero-substitution patterns: B8ZS at the T1 rate and HDB3 at the E1 rate. It flags any symbol that breaks the line code. When decoding is inactive, every mark passes as a one and every bipolar violation is flagged.

Decoding for a channel is active only when single-rail operation is selected. A global code bit turns it on for every channel. Otherwise each channel's own bit decides. The resulting per-channel enable is also exported, so the transmit encoder of the same channel follows it.

The bit strobe acts as the input valid. There is no ready signal, because a line cannot be paused: a symbol is taken on every strobe. Each strobe produces a one-cycle output valid pulse that carries the symbol taken eight strobes earlier. Nothing moves between strobes.

Top module: `zs_rx_decoder`

## Requirements
- R1: Decoding on channel i is active exactly when dual_rail is 0 and (global_code is 1 or chan_code[i] is 1). With dual_rail at 1 no channel decodes, whatever the code bits say.
- R2: tx_code_en[i] always equals the decode-active state of channel i as defined in R1.
- R3: After reset, each strobe on bit_en[i] gives rx_valid[i] high for exactly the next cycle, carrying the symbol taken 8 strobes earlier. For the first 8 strobes after reset the output is a zero with no violation. rx_valid is low in cycles that do not follow a strobe.
- R4: With decoding active and t1_mode = 1, the symbol group 0,0,0,V,B,0,V,B (V = a mark with the same polarity as the previous mark, B = a mark with the opposite polarity) leaves as eight zeros, with no violation flagged.
- R5: With decoding active and t1_mode = 0, the groups 0,0,0,V and B,0,0,V leave as four zeros, with no violation flagged.
- R6: With decoding active, a same-polarity mark that is not part of a valid substitution group leaves as a one with rx_viol high.
- R7: A symbol with both rails high leaves as a one with rx_viol high in every mode. It does not change the polarity reference used to judge later marks.
- R8: With decoding inactive, every mark leaves as a one and every mark with the same polarity as the preceding single-rail mark has rx_viol high. Zeros leave as zeros.
- R9: Reset clears the window and the outputs, and it forgets the polarity reference, so the first mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | NCH | Per-channel bit strobe (input valid) |
| rx_pos | input | NCH | Positive rail per channel |
| rx_neg | input | NCH | Negative rail per channel |
| t1_mode | input | 1 | 1 = B8ZS groups, 0 = HDB3 groups |
| dual_rail | input | 1 | 1 = dual-rail output mode, decoding off |
| global_code | input | 1 | Forces decoding on for every channel |
| chan_code | input | NCH | Per-channel decode enable |
| rx_valid | output | NCH | One-cycle output valid per channel |
| rx_data | output | NCH | Single-rail decoded data |
| rx_viol | output | NCH | Violation pulse, qualified by rx_valid |
| tx_code_en | output | NCH | Coupled substitution-encoder enable |

## Verification
Substitution removal on a decoding channel and raw violation flagging on a non-decoding channel fall in the same cycle. The bench provokes this by driving one encoded stream into all channels with a mixed enable pattern. Each output strobe then judges one channel against the source data and its neighbour against a bipolar-rule model of the line symbols. The same streams carry a both-rails symbol and a stray same-polarity mark. These show a code violation being released on the same strobe on which the decoding channel strips nearby substitution groups.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int ZS_WIN = 8;

  typedef struct packed {
    logic p;
    logic n;
    logic viol;
  } zs_sym_t;

  function automatic logic zs_is_zero(input zs_sym_t s);
    return !s.p && !s.n;
  endfunction

  // single-rail mark breaking alternation
  function automatic logic zs_is_v(input zs_sym_t s);
    return (s.p ^ s.n) && s.viol;
  endfunction

  // single-rail mark obeying alternation
  function automatic logic zs_is_b(input zs_sym_t s);
    return (s.p ^ s.n) && !s.viol;
  endfunction
endpackage

// File: rtl/zs_mark_class.sv
module zs_mark_class
  import zs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe,
  input  logic    p,
  input  logic    n,
  output zs_sym_t sym
);
  logic last_p, last_n;

  always_comb begin
    sym.p    = p;
    sym.n    = n;
    sym.viol = (p & n) | (p & ~n & last_p) | (n & ~p & last_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_p <= 1'b0;
      last_n <= 1'b0;
    end else if (strobe && (p ^ n)) begin
      last_p <= p;
      last_n <= n;
    end
  end

  // R8
  pos_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && p && !n) |=> (last_p && !last_n));

  // R7
  dbl_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && p && n) |=> $stable({last_p, last_n}));
endmodule

// File: rtl/zs_sub_window.sv
module zs_sub_window
  import zs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe,
  input  logic    dec_en,
  input  logic    t1_mode,
  input  zs_sym_t sym_in,
  output logic    out_valid,
  output logic    out_data,
  output logic    out_viol
);
  localparam int HD_LEN = ZS_WIN / 2;

  zs_sym_t win  [ZS_WIN];
  zs_sym_t cand [ZS_WIN];
  zs_sym_t nxt  [ZS_WIN];
  logic    b8_hit, hd_hit;

  always_comb begin
    cand[0] = sym_in;
    for (int i = 1; i < ZS_WIN; i++) cand[i] = win[i-1];
  end

  // index 0 is the newest symbol
  always_comb begin
    b8_hit = zs_is_b(cand[0]) && zs_is_v(cand[1]) && zs_is_zero(cand[2]) &&
             zs_is_b(cand[3]) && zs_is_v(cand[4]) && zs_is_zero(cand[5]) &&
             zs_is_zero(cand[6]) && zs_is_zero(cand[7]);
    hd_hit = zs_is_v(cand[0]) && zs_is_zero(cand[1]) && zs_is_zero(cand[2]) &&
             (zs_is_zero(cand[3]) || zs_is_b(cand[3]));
  end

  always_comb begin
    for (int i = 0; i < ZS_WIN; i++) begin
      nxt[i] = cand[i];
      if (dec_en && t1_mode && b8_hit) nxt[i] = '0;
      if (dec_en && !t1_mode && hd_hit && i < HD_LEN) nxt[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ZS_WIN; i++) win[i] <= '0;
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_viol  <= 1'b0;
    end else begin
      out_valid <= strobe;
      out_viol  <= strobe && win[ZS_WIN-1].viol;
      if (strobe) begin
        out_data <= win[ZS_WIN-1].p | win[ZS_WIN-1].n;
        for (int i = 0; i < ZS_WIN; i++) win[i] <= nxt[i];
      end
    end
  end

  // R3
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(strobe));

  // R6
  viol_is_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_viol |-> (out_valid && out_data));

  // R7
  dbl_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sym_in.p && sym_in.n) |=> win[0].viol);
endmodule

// File: rtl/zs_rx_decoder.sv
module zs_rx_decoder
  import zs_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] bit_en,
  input  logic [NCH-1:0] rx_pos,
  input  logic [NCH-1:0] rx_neg,
  input  logic           t1_mode,
  input  logic           dual_rail,
  input  logic           global_code,
  input  logic [NCH-1:0] chan_code,
  output logic [NCH-1:0] rx_valid,
  output logic [NCH-1:0] rx_data,
  output logic [NCH-1:0] rx_viol,
  output logic [NCH-1:0] tx_code_en
);
  logic [NCH-1:0] dec_en;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      dec_en[i] = !dual_rail && (global_code || chan_code[i]);
  end

  assign tx_code_en = dec_en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    zs_sym_t sym;

    zs_mark_class u_cls (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (bit_en[g]),
      .p      (rx_pos[g]),
      .n      (rx_neg[g]),
      .sym    (sym)
    );

    zs_sub_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (bit_en[g]),
      .dec_en    (dec_en[g]),
      .t1_mode   (t1_mode),
      .sym_in    (sym),
      .out_valid (rx_valid[g]),
      .out_data  (rx_data[g]),
      .out_viol  (rx_viol[g])
    );
  end

  // R1
  dual_blocks_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_rail |-> (tx_code_en == '0));

  // R2
  global_forces_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_rail && global_code) |-> (&tx_code_en));
endmodule

// File: tb/zs_rx_decoder_bench.sv
module zs_rx_decoder_bench;
  localparam int NCH = 4;
  localparam int N   = 240;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] bit_en, rx_pos, rx_neg, chan_code;
  logic t1_mode, dual_rail, global_code;
  logic [NCH-1:0] rx_valid, rx_data, rx_viol, tx_code_en;

  always #10 clk = ~clk;

  zs_rx_decoder #(.NCH(NCH)) u_zs_rx_decoder (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .t1_mode(t1_mode), .dual_rail(dual_rail), .global_code(global_code),
    .chan_code(chan_code), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_viol(rx_viol), .tx_code_en(tx_code_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit dat [N];
  bit sp [N], sn [N];
  bit ed [N], ev [N];
  bit rd [N], rv [N];
  int ka, kb;

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic gen_data();
    logic [31:0] s = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin
      int ln = 4 + (i / 40) % 9;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      dat[i] = s[0];
      if ((i % 40) >= 10 && (i % 40) < 10 + ln) dat[i] = 0;
    end
    dat[0] = 1;
    ka = -1; kb = -1;
    for (int k = 100; k < 160; k++)
      if (ka < 0 && dat[k-1] && !dat[k] && dat[k+1]) ka = k;
    for (int k = 170; k < 230; k++)
      if (kb < 0 && dat[k-1] && !dat[k] && dat[k+1]) kb = k;
  endtask

  task automatic encode(input bit t1);
    bit lastpos = 0;
    int marks = 0;
    int i = 0;
    for (int k = 0; k < N; k++) begin sp[k] = 0; sn[k] = 0; ed[k] = dat[k]; ev[k] = 0; end
    while (i < N) begin
      bit z8 = (i + 7 < N);
      bit z4 = (i + 3 < N);
      for (int m = 0; m < 8; m++) if (i + m < N && dat[i+m]) begin z8 = 0; if (m < 4) z4 = 0; end
      if (t1 && z8) begin
        sp[i+3] = lastpos;  sn[i+3] = !lastpos;
        sp[i+4] = !lastpos; sn[i+4] = lastpos;
        sp[i+6] = !lastpos; sn[i+6] = lastpos;
        sp[i+7] = lastpos;  sn[i+7] = !lastpos;
        i += 8;
      end else if (!t1 && z4) begin
        if (marks % 2 == 0) begin
          lastpos = !lastpos;
          sp[i] = lastpos; sn[i] = !lastpos;
        end
        sp[i+3] = lastpos; sn[i+3] = !lastpos;
        marks = 0;
        i += 4;
      end else begin
        if (dat[i]) begin
          lastpos = !lastpos;
          sp[i] = lastpos; sn[i] = !lastpos;
          marks++;
        end
        i++;
      end
    end
    // corruption A: both rails; corruption B: stray same-polarity mark
    sp[ka] = 1; sn[ka] = 1; ed[ka] = 1; ev[ka] = 1;
    sp[kb] = sp[kb-1]; sn[kb] = sn[kb-1]; ed[kb] = 1; ev[kb] = 1;
    begin
      bit lp = 0, lnn = 0;
      for (int k = 0; k < N; k++) begin
        rd[k] = sp[k] | sn[k];
        rv[k] = (sp[k] & sn[k]) | (sp[k] & !sn[k] & lp) | (sn[k] & !sp[k] & lnn);
        if (sp[k] ^ sn[k]) begin lp = sp[k]; lnn = sn[k]; end
      end
    end
  endtask

  task automatic do_reset();
    bit_en = '0; rx_pos = '0; rx_neg = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9
    chk("R9 reset valid", rx_valid, '0);
    chk("R9 reset data", rx_data, '0);
    chk("R9 reset viol", rx_viol, '0);
  endtask

  task automatic run_stream(input bit t1, input bit dual, input bit glob, input logic [NCH-1:0] cc);
    logic [NCH-1:0] dec;
    encode(t1);
    t1_mode = t1; dual_rail = dual; global_code = glob; chan_code = cc;
    do_reset();
    for (int c = 0; c < NCH; c++) dec[c] = !dual && (glob || cc[c]);
    chk("R2 coupled enable", tx_code_en, dec);
    for (int j = 0; j < N + LAT; j++) begin
      logic [NCH-1:0] xd, xv;
      string tag;
      @(negedge clk);
      bit_en = '1;
      rx_pos = (j < N && sp[j]) ? '1 : '0;
      rx_neg = (j < N && sn[j]) ? '1 : '0;
      @(negedge clk);
      bit_en = '0; rx_pos = '0; rx_neg = '0;
      tag = dual ? "R1" : (t1 ? "R4" : "R5");
      if (j < LAT) begin
        xd = '0; xv = '0; tag = "R3";
      end else begin
        int k = j - LAT;
        if (k == ka) tag = "R7";
        if (k == kb) tag = dec != 0 ? "R6" : "R8";
        for (int c = 0; c < NCH; c++) begin
          xd[c] = dec[c] ? ed[k] : rd[k];
          xv[c] = dec[c] ? ev[k] : rv[k];
        end
        if (dec != '1 && rv[k]) tag = "R8";
      end
      chk("R3 valid pulse", rx_valid, '1);
      chk({tag, " data"}, rx_data, xd);
      chk({tag, " viol"}, rx_viol, xv);
    end
    @(negedge clk);
    // R3: no strobe, no valid
    chk("R3 idle valid", rx_valid, '0);
    chk("R3 idle viol", rx_viol, '0);
  endtask

  initial begin
    t1_mode = 0; dual_rail = 0; global_code = 0; chan_code = '0;
    do_reset();
    // R1 / R2 exhaustive control sweep
    for (int d = 0; d < 2; d++)
      for (int g = 0; g < 2; g++)
        for (int cc = 0; cc < 16; cc++) begin
          logic [NCH-1:0] exp;
          @(negedge clk);
          dual_rail = d[0]; global_code = g[0]; chan_code = cc[NCH-1:0];
          #1;
          for (int c = 0; c < NCH; c++) exp[c] = !d[0] && (g[0] || cc[c]);
          chk("R1 R2 enable sweep", tx_code_en, exp);
        end
    gen_data();
    for (int t = 0; t < 2; t++) begin
      run_stream(t[0], 1'b0, 1'b0, 4'b0101);
      run_stream(t[0], 1'b0, 1'b1, 4'b0000);
      run_stream(t[0], 1'b1, 1'b1, 4'b1111);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule